// File: doc/BRIEF.md
# Direct-Mapped Copy-Back Data Cache

This block is a direct-mapped data cache that sits between a processor port and a word-wide main-memory port. It works on 24-bit byte addresses and holds 16 KB as 256 lines of eight 64-bit words. Each line has a directory entry made of a tag, a valid flag, a modified flag and a touched flag. Loads and stores that hit finish in the cycle they are presented. Stores update only the cache and mark the line modified. A store that misses first brings the line in and then writes into it.

On a miss the controller checks the victim line. A clean victim is overwritten. A modified victim is first sent to memory as eight words. The new line is then fetched, starting at the word that missed and wrapping around the line. The waiting processor request completes in the same cycle that its word arrives. The rest of the line keeps streaming in, and every processor request stalls until the line is complete.

The processor holds `cpu_req` and its address, command and data steady while `cpu_stall` is high. The request completes on the first rising edge at which `cpu_stall` is low.

Top module: `dm_cb_cache`

## Requirements
- R1: The byte address splits as tag = bits [23:14], line index = bits [13:6], word in line = bits [5:3]. Bits [2:0] select nothing: every access moves a whole 64-bit word. The memory port carries word addresses {tag, index, word} (21 bits).
- R2: After reset no line is valid, the memory port is idle, and the first access to any address misses (`cpu_stall` high).
- R3: A request hits when the indexed entry is valid and its tag equals the address tag. A hit completes with `cpu_stall` low in the cycle it is presented, makes no memory transfer, and a load returns the last value stored to that word, or the memory value if the word was never stored. Every completed access sets the line's touched flag.
- R4: A store hit writes only the cache word and marks the line modified. Memory is not written.
- R5: On a miss with a clean or invalid victim, no write transfer occurs. Eight read transfers fetch the line in word order m, m+1, ... wrapping modulo 8, where m is the missed word.
- R6: On a miss with a modified victim, eight write transfers send the old line to {old tag, index, 0..7} in ascending word order, carrying the current cache contents, and all of them finish before the first read transfer.
- R7: The missed request completes in the cycle its word is transferred (the first read transfer). A load returns that memory word, and a store replaces it with the store data.
- R8: While a fill is still in progress after the early completion, every processor request stalls until the last fill word has been transferred.
- R9: A store miss leaves the line valid and modified and holds the store data. Memory receives that data only when the line is evicted later.
- R10: A memory transfer completes on a rising edge with `mem_valid` and `mem_ready` both high. While `mem_ready` is low, `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request pending |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 24 | Byte address |
| cpu_wdata | input | 64 | Store data |
| cpu_rdata | output | 64 | Load data, valid when the request completes |
| cpu_stall | output | 1 | High while the pending request is not serviced |
| mem_valid | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = write-back word, 0 = fill read |
| mem_addr | output | 21 | Memory word address |
| mem_wdata | output | 64 | Write-back data |
| mem_ready | input | 1 | Memory accepts or returns the word this cycle |
| mem_rdata | input | 64 | Fill data, valid when `mem_ready` is high on a read |

## Verification
The assertions assume that the processor keeps `cpu_addr`, `cpu_we` and `cpu_wdata` steady from the moment it raises `cpu_req` until the request completes. The fill-start check compares the first fill address against the live processor address, so it depends on this. They also assume that `mem_rdata` is valid whenever `mem_ready` is high on a read. The bench drives a request only at falling edges, holds it through every stall cycle, and drops it just after the completing edge. Its memory model updates `mem_ready` and `mem_rdata` only at falling edges, with a pseudo-random ready pattern that exercises back-pressure on both write-back and fill transfers.

// File: rtl/dm_cb_cache.sv
module dm_cb_cache #(
  parameter int TAG_W  = 10,
  parameter int IDX_W  = 8,
  parameter int WSEL_W = 3,
  parameter int BSEL_W = 3,
  parameter int DATA_W = 64
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cpu_req,
  input  logic                                  cpu_we,
  input  logic [TAG_W+IDX_W+WSEL_W+BSEL_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]                     cpu_wdata,
  output logic [DATA_W-1:0]                     cpu_rdata,
  output logic                                  cpu_stall,
  output logic                                  mem_valid,
  output logic                                  mem_we,
  output logic [TAG_W+IDX_W+WSEL_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]                     mem_wdata,
  input  logic                                  mem_ready,
  input  logic [DATA_W-1:0]                     mem_rdata
);
  localparam int AW    = TAG_W + IDX_W + WSEL_W + BSEL_W;
  localparam int LINES = 1 << IDX_W;
  localparam int WPL   = 1 << WSEL_W;
  localparam logic [WSEL_W-1:0] LAST = WSEL_W'(WPL - 1);

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL} st_t;

  st_t                     st;
  logic [WSEL_W-1:0]       cnt;
  logic [LINES-1:0]        valid, dirty, refb;
  logic [TAG_W-1:0]        tag_q [LINES];
  logic [DATA_W-1:0]       dat   [LINES*WPL];
  logic [TAG_W-1:0]        m_tag;
  logic [IDX_W-1:0]        m_idx;
  logic [WSEL_W-1:0]       m_word;

  logic [TAG_W-1:0]  c_tag;
  logic [IDX_W-1:0]  c_idx;
  logic [WSEL_W-1:0] c_wrd;
  logic              unused_bsel;
  assign c_tag       = cpu_addr[AW-1 -: TAG_W];
  assign c_idx       = cpu_addr[BSEL_W+WSEL_W +: IDX_W];
  assign c_wrd       = cpu_addr[BSEL_W +: WSEL_W];
  assign unused_bsel = ^cpu_addr[BSEL_W-1:0];

  logic              hit, serve_hit, rel, st_merge;
  logic [WSEL_W-1:0] fw;
  logic [DATA_W-1:0] fill_d;
  assign hit       = valid[c_idx] && (tag_q[c_idx] == c_tag);
  assign serve_hit = (st == S_IDLE) && hit;
  assign rel       = (st == S_FILL) && (cnt == '0) && mem_ready;
  assign st_merge  = rel && cpu_req && cpu_we;
  assign fw        = m_word + cnt;
  assign fill_d    = st_merge ? cpu_wdata : mem_rdata;

  assign cpu_stall = cpu_req && !(serve_hit || rel);
  assign cpu_rdata = rel ? mem_rdata : dat[{c_idx, c_wrd}];
  assign mem_valid = (st != S_IDLE);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = (st == S_WB) ? {tag_q[m_idx], m_idx, cnt} : {m_tag, m_idx, fw};
  assign mem_wdata = dat[{m_idx, cnt}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      valid  <= '0;
      dirty  <= '0;
      refb   <= '0;
      m_tag  <= '0;
      m_idx  <= '0;
      m_word <= '0;
    end else begin
      case (st)
        S_IDLE: if (cpu_req) begin
          if (hit) begin
            refb[c_idx] <= 1'b1;
            if (cpu_we) dirty[c_idx] <= 1'b1;
          end else begin
            m_tag        <= c_tag;
            m_idx        <= c_idx;
            m_word       <= c_wrd;
            cnt          <= '0;
            valid[c_idx] <= 1'b0;
            st           <= (valid[c_idx] && dirty[c_idx]) ? S_WB : S_FILL;
          end
        end
        S_WB: if (mem_ready) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= S_FILL;
        end
        S_FILL: if (mem_ready) begin
          cnt <= cnt + 1'b1;
          if (cnt == '0) begin
            refb[m_idx]  <= 1'b1;
            dirty[m_idx] <= cpu_req && cpu_we;
          end
          if (cnt == LAST) begin
            valid[m_idx] <= 1'b1;
            st           <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (serve_hit && cpu_req && cpu_we) dat[{c_idx, c_wrd}] <= cpu_wdata;
    if (st == S_FILL && mem_ready) begin
      dat[{m_idx, fw}] <= fill_d;
      if (cnt == LAST) tag_q[m_idx] <= m_tag;
    end
  end

  a_r10_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r6_wb_starts_at_word0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid && mem_we) |-> mem_addr[WSEL_W-1:0] == '0);

  a_r6_wb_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && mem_ready && (mem_addr[WSEL_W-1:0] != LAST) |=>
      mem_valid && mem_we && (mem_addr[WSEL_W-1:0] == WSEL_W'($past(mem_addr[WSEL_W-1:0]) + 1'b1)));

  a_r5_fill_starts_at_missed_word: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_we && !$past(mem_valid && !mem_we) |->
      mem_addr[WSEL_W-1:0] == c_wrd && mem_addr[TAG_W+IDX_W+WSEL_W-1 -: TAG_W] == c_tag);

  a_r8_no_service_mid_fill: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_FILL && cnt != '0 |-> !(cpu_req && !cpu_stall));

  a_r4_store_hit_no_traffic: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && cpu_req && cpu_we && !cpu_stall |=> !mem_valid);

  a_r3_touched_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_stall |=> refb[$past(c_idx)]);
endmodule

// File: tb/dm_cb_cache_test.sv
module dm_cb_cache_test;
  logic        clk = 0, rst_n = 0;
  logic        cpu_req = 0, cpu_we = 0;
  logic [23:0] cpu_addr = '0;
  logic [63:0] cpu_wdata = '0, cpu_rdata;
  logic        cpu_stall, mem_valid, mem_we, mem_ready = 0;
  logic [20:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata = '0;

  dm_cb_cache uut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  logic [63:0] bmem [int];
  logic [63:0] model [int];
  logic [20:0] rlog [64];
  logic [20:0] wlog [64];
  logic [63:0] wdlog [64];
  int rn = 0, wn = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic pv = 0, pr = 0, pw = 0;
  logic [20:0] pa = '0;

  function automatic logic [63:0] pat(input logic [20:0] a);
    return {a, 11'h5A3, ~a, 11'h03C};
  endfunction

  function automatic logic [23:0] mk(input int t, input int i, input int w, input int b);
    return {10'(t), 8'(i), 3'(w), 3'(b)};
  endfunction

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && pv && !pr)
      chk(mem_valid && mem_addr == pa && mem_we == pw, "R10 hold", {42'd0, mem_addr}, {42'd0, pa});
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = rst_n && mem_valid && (lfsr[0] | lfsr[2]);
    mem_rdata = bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : pat(mem_addr);
    if (mem_ready) begin
      if (mem_we) begin
        bmem[int'(mem_addr)] = mem_wdata;
        if (wn < 64) begin wlog[wn] = mem_addr; wdlog[wn] = mem_wdata; end
        wn++;
      end else begin
        if (rn < 64) rlog[rn] = mem_addr;
        rn++;
      end
    end
    pv = mem_valid; pr = mem_ready; pw = mem_we; pa = mem_addr;
  end

  function automatic logic [63:0] expect_word(input logic [23:0] a);
    int k = int'(a[23:3]);
    return model.exists(k) ? model[k] : pat(a[23:3]);
  endfunction

  int rel_rn, rel_wn;
  task automatic acc(input bit we, input logic [23:0] a, input logic [63:0] d,
                     output logic [63:0] q, output int waits);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1;
    waits = 0;
    while (cpu_stall && waits < 3000) begin
      @(negedge clk); #1; waits++;
    end
    q = cpu_rdata; rel_rn = rn; rel_wn = wn;
    if (we) model[int'(a[23:3])] = d;
    @(posedge clk); #1;
    cpu_req = 0;
  endtask

  task automatic settle();
    int n = 0;
    @(negedge clk); #1;
    while (mem_valid && n < 3000) begin @(negedge clk); #1; n++; end
  endtask

  task automatic clr();
    rn = 0; wn = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] q;
    int w;
    logic [63:0] X, Y;
    X = 64'hDEAD_BEEF_0123_4567;
    Y = 64'h0F1E_2D3C_4B5A_6978;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    chk(!mem_valid && !cpu_stall, "R2 idle after reset", {63'd0, mem_valid}, 64'd0);

    clr();
    acc(0, mk(1, 5, 3, 0), 0, q, w);
    chk(w > 0, "R2 first access misses", 64'(w), 64'd1);
    chk(q == pat(mk(1,5,3,0) >> 3), "R7 early load data", q, pat(mk(1,5,3,0) >> 3));
    chk(rel_rn == 1, "R7 release on first fill word", 64'(rel_rn), 64'd1);
    settle();
    chk(rn == 8, "R5 eight fill reads", 64'(rn), 64'd8);
    chk(wn == 0, "R5 clean victim no write", 64'(wn), 64'd0);
    for (int k = 0; k < 8; k++)
      chk(rlog[k] == {10'd1, 8'd5, 3'((3 + k) % 8)}, "R5 wrap order",
          {43'd0, rlog[k]}, {43'd0, 10'd1, 8'd5, 3'((3 + k) % 8)});

    clr();
    acc(0, mk(1, 5, 6, 7), 0, q, w);
    chk(w == 0 && rn == 0, "R3 hit no stall no traffic", 64'(w + rn), 64'd0);
    chk(q == pat(mk(1,5,6,0) >> 3), "R1 byte bits ignored", q, pat(mk(1,5,6,0) >> 3));

    acc(1, mk(1, 5, 2, 0), X, q, w);
    chk(w == 0, "R4 store hit no stall", 64'(w), 64'd0);
    chk(!bmem.exists(int'(mk(1,5,2,0) >> 3)) && wn == 0, "R4 memory untouched", 64'(wn), 64'd0);
    acc(0, mk(1, 5, 2, 4), 0, q, w);
    chk(q == X && w == 0, "R4 store visible", q, X);

    clr();
    acc(0, mk(2, 9, 7, 0), 0, q, w);
    acc(0, mk(1, 5, 0, 0), 0, q, w);
    chk(rel_rn == 8, "R8 stall until fill complete", 64'(rel_rn), 64'd8);
    chk(w > 0, "R8 request stalled during fill", 64'(w), 64'd1);

    clr();
    acc(0, mk(3, 5, 4, 0), 0, q, w);
    chk(rel_wn == 8, "R6 writeback before fill", 64'(rel_wn), 64'd8);
    chk(q == pat(mk(3,5,4,0) >> 3), "R7 load after writeback", q, pat(mk(3,5,4,0) >> 3));
    settle();
    for (int k = 0; k < 8; k++) begin
      logic [63:0] e;
      e = (k == 2) ? X : pat({10'd1, 8'd5, 3'(k)});
      chk(wlog[k] == {10'd1, 8'd5, 3'(k)}, "R6 writeback address order",
          {43'd0, wlog[k]}, {43'd0, 10'd1, 8'd5, 3'(k)});
      chk(wdlog[k] == e, "R6 writeback data", wdlog[k], e);
    end

    clr();
    acc(1, mk(4, 20, 5, 0), Y, q, w);
    chk(w > 0, "R9 store miss stalls", 64'(w), 64'd1);
    settle();
    acc(0, mk(4, 20, 5, 0), 0, q, w);
    chk(q == Y && w == 0, "R9 store data allocated", q, Y);
    chk(wn == 0 && !bmem.exists(int'(mk(4,20,5,0) >> 3)), "R9 no memory write yet", 64'(wn), 64'd0);
    clr();
    acc(0, mk(5, 20, 0, 0), 0, q, w);
    settle();
    chk(wn == 8 && wdlog[5] == Y, "R9 modified line written back", wdlog[5], Y);

    for (int s = 0; s < 8; s++) begin
      clr();
      acc(s % 2, mk(6, 30 + s, s, 0), 64'(s) * 64'h1111, q, w);
      chk(rel_rn == 1 && rlog[0][2:0] == 3'(s), "R5 fill starts at missed word",
          {61'd0, rlog[0][2:0]}, 64'(s));
      if (s % 2 == 0)
        chk(q == pat(mk(6,30+s,s,0) >> 3), "R7 sweep load", q, pat(mk(6,30+s,s,0) >> 3));
      settle();
      acc(0, mk(6, 30 + s, s, 0), 0, q, w);
      chk(q == expect_word(mk(6,30+s,s,0)), "R7 merged word kept", q, expect_word(mk(6,30+s,s,0)));
    end

    for (int n = 0; n < 3000; n++) begin
      logic [23:0] a;
      bit we;
      logic [63:0] d;
      a  = mk($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 7));
      we = ($urandom_range(0, 9) < 3);
      d  = {$urandom, $urandom};
      if (!we) begin
        logic [63:0] e;
        e = expect_word(a);
        acc(0, a, 0, q, w);
        chk(q == e, "R3 load matches flat memory", q, e);
      end else acc(1, a, d, q, w);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule